// File: doc/BRIEF.md
# Power-Good Sequencer with Strap Capture

This block runs the power-up sequence of a clock-generator controller. A single active-low pin first acts as a power-good indication. While the block waits for that pin, the clock outputs stay disabled and nothing is latched. Once the pin has been seen low for a debounce interval, the block captures the strap inputs into holding registers. The strap inputs are the frequency-select bits and a strap that decides whether the software-reset pin may be used. The block then waits a lock interval and enables the outputs.

After that first capture the pin takes a second role: a high level on it requests power-down. The pin is asynchronous, so it passes through a synchronizer before the sequencer sees it. A power-down request turns the outputs off. When the request is released, the block waits the full lock interval again before it turns the outputs back on. Later toggles of the pin never restart the power-up sequence and never capture the straps again. All delays are parameters counted in reference-clock cycles.

Top module: `pgood_seq_ctrl`

## Requirements
- R1: While reset is held, and afterwards until the first capture, `state_o` reads 0 (idle), `clk_oe_o` is 0, and both latched strap outputs read 0.
- R2: The pin passes through a two-flop synchronizer. The synchronized level must stay low for `DEB_CYC` consecutive cycles before the block leaves idle. A shorter low pulse leaves the block in idle. If the pin is driven low just before rising edge 1, `state_o` reads 1 (sample) after edge `2+DEB_CYC`.
- R3: The capture happens in the single sample-state cycle. It loads `strap_fs_i` into `fs_latched_o` and `strap_rst_en_i` into `rst_en_latched_o`.
- R4: The outputs are enabled and `state_o` reads 3 (run) after rising edge `3+DEB_CYC+LOCK_CYC`, counted from the first low pin sample.
- R5: After capture, changes on the strap inputs have no effect on the latched strap outputs.
- R6: After capture the block never returns to idle or sample, whatever the pin does.
- R7: In run, a high pin level is a power-down request. If the pin is raised just before edge 1, `clk_oe_o` is 0 and `state_o` reads 2 (wait-lock) after edge 3.
- R8: While the power-down request is held, the block stays in wait-lock with the outputs off. Each request restarts the lock count. If the pin is lowered just before edge 1, run is entered after edge `2+LOCK_CYC`.
- R9: `clk_oe_o` is 1 exactly when `state_o` reads 3. The state encoding is idle=0, sample=1, wait-lock=2, run=3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pg_pin_i | input | 1 | Asynchronous shared pin: active-low power-good, then active-high power-down |
| strap_fs_i | input | FS_W | Frequency-select strap bits |
| strap_rst_en_i | input | 1 | Strap that enables the software-reset pin |
| fs_latched_o | output | FS_W | Captured frequency-select straps |
| rst_en_latched_o | output | 1 | Captured reset-enable strap (software-reset pin usable) |
| clk_oe_o | output | 1 | Clock output enable |
| state_o | output | 2 | Sequencer state: 0 idle, 1 sample, 2 wait-lock, 3 run |

## Verification
The bench sweeps every strap combination of a small configuration. For each one it counts the edges to each state change and compares them with the arithmetic from R2, R4, R7 and R8. A debounce counter that is not cleared by a high level would accept a short glitch, and the bench would see the sample state too early. A lock counter that kept counting during power-down would re-enable the outputs before `2+LOCK_CYC` edges. A latch that stayed transparent would follow the inverted straps the bench drives after capture. A sequencer that treated a later high pin as "not yet good" would fall back to idle, and the bench monitor would flag that.

// File: rtl/pgseq_pkg.sv
// Shared types for the power-good sequencer.
// Assumes nothing beyond standard SystemVerilog packages.
package pgseq_pkg;

    // Sequencer states; encoding is visible on the state port.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SAMPLE = 2'd1,
        ST_WAIT   = 2'd2,
        ST_RUN    = 2'd3
    } seq_state_t;

endpackage

// File: rtl/pgseq_sync.sv
// Multi-stage synchronizer for one asynchronous level.
// Assumes the input is a slow level; reset loads RST_VAL into every stage.
module pgseq_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain_q;

    generate
        genvar gi;
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                // First flop: samples the asynchronous input.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[gi] <= RST_VAL;
                    else        chain_q[gi] <= d_i;
                end
            end else begin : g_rest
                // Later flops: resolve metastability.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[gi] <= RST_VAL;
                    else        chain_q[gi] <= chain_q[gi-1];
                end
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/pgseq_counter.sv
// Shared saturating delay counter with clear and increment.
// Assumes clear wins over increment; saturates at MAX_CNT.
module pgseq_counter #(
    parameter int MAX_CNT = 16,
    localparam int CNT_W  = $clog2(MAX_CNT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] TOP = CNT_W'(MAX_CNT);

    logic [CNT_W-1:0] cnt_q;

    // Count cycles; clear has priority; hold at the top.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i)             cnt_q <= '0;
        else if (inc_i && cnt_q != TOP)  cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;

    // Counter must never pass its limit (R4, R8 timing relies on it).
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= TOP);

endmodule

// File: rtl/pgseq_strap_latch.sv
// Holding registers for the strap inputs.
// Assumes capture_i pulses exactly once after reset; the registers read zero before that.
module pgseq_strap_latch #(
    parameter int FS_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            capture_i,
    input  logic [FS_W-1:0] fs_i,
    input  logic            rst_en_i,
    output logic [FS_W-1:0] fs_o,
    output logic            rst_en_o
);

    logic [FS_W-1:0] fs_q;
    logic            rst_en_q;

    // Load the straps on the capture pulse, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fs_q     <= '0;
            rst_en_q <= 1'b0;
        end else if (capture_i) begin
            fs_q     <= fs_i;
            rst_en_q <= rst_en_i;
        end
    end

    assign fs_o     = fs_q;
    assign rst_en_o = rst_en_q;

    // Without a capture the held straps stay put (R5).
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !capture_i |=> ($stable(fs_q) && $stable(rst_en_q)));

endmodule

// File: rtl/pgood_seq_ctrl.sv
// Power-good sequencer: debounces the shared pin, captures the straps once,
// waits for lock, then gates the clock output enable with power-down requests.
// Assumes DEB_CYC >= 1 and LOCK_CYC >= 1, and a synchronous active-low reset.
module pgood_seq_ctrl #(
    parameter int FS_W     = 5,
    parameter int DEB_CYC  = 3600,
    parameter int LOCK_CYC = 25000,
    parameter int SYNC_STG = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pg_pin_i,
    input  logic [FS_W-1:0] strap_fs_i,
    input  logic            strap_rst_en_i,
    output logic [FS_W-1:0] fs_latched_o,
    output logic            rst_en_latched_o,
    output logic            clk_oe_o,
    output logic [1:0]      state_o
);

    import pgseq_pkg::*;

    localparam int MAX_CNT = (DEB_CYC > LOCK_CYC) ? DEB_CYC : LOCK_CYC;
    localparam int CNT_W   = $clog2(MAX_CNT + 1);
    localparam logic [CNT_W-1:0] DEB_LAST  = CNT_W'(DEB_CYC - 1);
    localparam logic [CNT_W-1:0] LOCK_LAST = CNT_W'(LOCK_CYC - 1);

    logic             pin_s;
    logic [CNT_W-1:0] cnt;
    logic             cnt_clr;
    logic             cnt_inc;
    logic             capture;
    seq_state_t       state_q;
    seq_state_t       state_nx;
    logic             oe_q;

    // Bring the asynchronous pin into the clock domain; idle level is high.
    pgseq_sync #(
        .STAGES  (SYNC_STG),
        .RST_VAL (1'b1)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pg_pin_i),
        .q_o   (pin_s)
    );

    // One counter serves both the debounce and the lock interval.
    pgseq_counter #(
        .MAX_CNT (MAX_CNT)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (cnt_clr),
        .inc_i (cnt_inc),
        .cnt_o (cnt)
    );

    // Strap holding registers, loaded once in the sample state.
    pgseq_strap_latch #(
        .FS_W (FS_W)
    ) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (capture),
        .fs_i      (strap_fs_i),
        .rst_en_i  (strap_rst_en_i),
        .fs_o      (fs_latched_o),
        .rst_en_o  (rst_en_latched_o)
    );

    // Next-state and counter control for the sequence.
    always_comb begin
        state_nx = state_q;
        cnt_clr  = 1'b0;
        cnt_inc  = 1'b0;
        capture  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (pin_s) begin
                    cnt_clr = 1'b1;
                end else if (cnt == DEB_LAST) begin
                    state_nx = ST_SAMPLE;
                    cnt_clr  = 1'b1;
                end else begin
                    cnt_inc = 1'b1;
                end
            end
            ST_SAMPLE: begin
                capture  = 1'b1;
                cnt_clr  = 1'b1;
                state_nx = ST_WAIT;
            end
            ST_WAIT: begin
                if (pin_s) begin
                    cnt_clr = 1'b1;
                end else if (cnt == LOCK_LAST) begin
                    state_nx = ST_RUN;
                    cnt_clr  = 1'b1;
                end else begin
                    cnt_inc = 1'b1;
                end
            end
            ST_RUN: begin
                if (pin_s) begin
                    state_nx = ST_WAIT;
                    cnt_clr  = 1'b1;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register and registered output enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            oe_q    <= 1'b0;
        end else begin
            state_q <= state_nx;
            oe_q    <= (state_nx == ST_RUN);
        end
    end

    assign clk_oe_o = oe_q;
    assign state_o  = state_q;

    // Sample state is entered only after the pin was low (R2).
    p_debounce_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SAMPLE) |-> ($past(state_q) == ST_IDLE && !$past(pin_s)));

    // Sample lasts one cycle and leads to wait-lock (R3).
    p_sample_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SAMPLE) |=> (state_q == ST_WAIT));

    // Once out of idle, idle and sample are never seen again (R6).
    p_no_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT || state_q == ST_RUN) |=>
        (state_q == ST_WAIT || state_q == ST_RUN));

    // A power-down request in run drops to wait-lock (R7).
    p_pd_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && pin_s) |=> (state_q == ST_WAIT && !oe_q));

    // Run is never entered while power-down is requested (R8).
    p_run_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_q) |-> !$past(pin_s));

    // Output enable tracks the run state (R9).
    p_oe_state_r9: assert property (@(posedge clk) disable iff (!rst_n)
        oe_q == (state_q == ST_RUN));

endmodule

// File: tb/pgood_seq_ctrl_bench.sv
module pgood_seq_ctrl_bench;

    localparam int FS_W = 3;
    localparam int DEB  = 4;
    localparam int LOCK = 6;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            pin = 1'b1;
    logic [FS_W-1:0] fs_in = '0;
    logic            rsten_in = 1'b0;
    logic [FS_W-1:0] fs_lat;
    logic            rsten_lat;
    logic            oe;
    logic [1:0]      st;

    int total = 0;
    int bad = 0;
    bit done = 0;
    bit armed = 0;
    bit went_back = 0;

    always #2.5 clk = ~clk;

    pgood_seq_ctrl #(
        .FS_W     (FS_W),
        .DEB_CYC  (DEB),
        .LOCK_CYC (LOCK),
        .SYNC_STG (2)
    ) u_pgood_seq_ctrl (
        .clk              (clk),
        .rst_n            (rst_n),
        .pg_pin_i         (pin),
        .strap_fs_i       (fs_in),
        .strap_rst_en_i   (rsten_in),
        .fs_latched_o     (fs_lat),
        .rst_en_latched_o (rsten_lat),
        .clk_oe_o         (oe),
        .state_o          (st)
    );

    // Watch for a fall back to idle or sample after capture (R6).
    always @(negedge clk) if (armed && st < 2'd2) went_back = 1'b1;

    task automatic chk(input int act, input int exp, input string req);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Count rising edges until the state equals target (samples at negedge).
    task automatic edges_to_state(input logic [1:0] target, output int n);
        n = 0;
        for (int k = 0; k < 200; k++) begin
            @(posedge clk); n++;
            @(negedge clk);
            if (st == target) return;
        end
        n = -1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        for (int v = 0; v < (1 << (FS_W + 1)); v++) begin
            logic [FS_W-1:0] fsv;
            fsv = FS_W'(v);
            armed = 0; went_back = 0;
            @(negedge clk);
            rst_n = 0; pin = 1; fs_in = fsv; rsten_in = v[FS_W];
            repeat (3) @(posedge clk);
            @(negedge clk);
            chk(st, 0, "R1 state in reset");
            chk(oe, 0, "R1 oe in reset");
            rst_n = 1;
            repeat (3) @(posedge clk);
            @(negedge clk);
            chk(st, 0, "R1 state before capture");
            chk(oe, 0, "R1 oe before capture");
            chk(fs_lat, 0, "R1 fs before capture");
            chk(rsten_lat, 0, "R1 rst_en before capture");

            // Short low glitch must not leave idle (R2).
            pin = 0;
            repeat (DEB - 1) @(posedge clk);
            @(negedge clk); pin = 1;
            repeat (6) @(posedge clk);
            @(negedge clk);
            chk(st, 0, "R2 glitch ignored");
            chk(fs_lat, 0, "R2 no capture on glitch");

            // Real power-good: sample then run timing (R2, R4).
            pin = 0;
            edges_to_state(2'd1, n);
            chk(n, 2 + DEB, "R2 edges to sample");
            edges_to_state(2'd3, n);
            chk(n + 2 + DEB, 3 + DEB + LOCK, "R4 edges to run");
            chk(oe, 1, "R9 oe in run");
            chk(fs_lat, fsv, "R3 fs captured");
            chk(rsten_lat, v[FS_W], "R3 rst_en captured");
            armed = 1;

            // Strap changes after capture are ignored (R5).
            fs_in = ~fsv; rsten_in = ~v[FS_W];
            repeat (5) @(posedge clk);
            @(negedge clk);
            chk(fs_lat, fsv, "R5 fs held");
            chk(rsten_lat, v[FS_W], "R5 rst_en held");

            // Power-down from run (R7).
            pin = 1;
            repeat (2) @(posedge clk);
            @(negedge clk);
            chk(oe, 1, "R7 oe still on after 2 edges");
            @(posedge clk);
            @(negedge clk);
            chk(oe, 0, "R7 oe off after 3 edges");
            chk(st, 2, "R7 wait-lock on power-down");

            // Held power-down keeps outputs off (R8).
            repeat (LOCK + 5) @(posedge clk);
            @(negedge clk);
            chk(st, 2, "R8 held in wait-lock");
            chk(oe, 0, "R9 oe off in wait-lock");

            // Release: lock wait again (R8).
            pin = 0;
            edges_to_state(2'd3, n);
            chk(n, 2 + LOCK, "R8 edges to run after release");

            // Second power-down, interrupted lock wait restarts the count (R8).
            pin = 1;
            repeat (4) @(posedge clk);
            @(negedge clk); pin = 0;
            repeat (3) @(posedge clk);
            @(negedge clk); pin = 1;
            repeat (3) @(posedge clk);
            @(negedge clk); pin = 0;
            edges_to_state(2'd3, n);
            chk(n, 2 + LOCK, "R8 restart after interrupted lock");
            chk(fs_lat, fsv, "R6 no recapture");
            chk(int'(went_back), 0, "R6 never back to idle or sample");
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule